// File: doc/BRIEF.md
# Dual-Issue Load-Use Stall Unit

This block is the hazard and issue controller for a two-wide in-order pipeline in which every result is forwarded. The only dependence that still costs a cycle is a load whose data is not ready yet. The block holds the decode-stage pair (older lane 0, younger lane 1) and a short record of the pair in the execute stage. Each cycle it checks the sources of both decode instructions against any load in the execute pair. It also checks the younger instruction's sources against the older one's destination. From these checks it decides which lanes advance.

Age order is enforced. A stalled older instruction also holds the younger one. A stalled younger instruction lets the older one go. When only the younger lane is held, a policy input picks the refill behaviour. In rigid mode, no new instruction may join the waiting one. In fluid mode, the held instruction moves up into the older lane and the next instruction in program order fills the younger lane. The fetch side is told how many presented instructions were consumed.

Top module: `dual_ldu_stall`

## Requirements
- R1: While reset is asserted and right after it is released, both decode lanes and both execute lanes are empty. In that state stall, grant, fetch_take and steer_up are all zero when no fetch group is presented.
- R2: The older decode lane stalls when a load in either execute lane has a destination equal to one of that instruction's read sources.
- R3: The younger decode lane stalls on the same load-use match against either execute lane.
- R4: The younger decode lane also stalls when one of its read sources equals the destination of a valid older decode instruction of class ALU (code 0) or LOAD (code 1). STORE (2) and BRANCH (3) write no register.
- R5: A stall of the older lane also stalls a valid younger lane, so that neither reaches execute on the next clock.
- R6: A younger-only stall still grants the older lane, and the older instruction appears in execute lane 0 on the next clock.
- R7: A non-load producer in execute never causes a stall, because forwarding covers it.
- R8: Register 0 never forms a dependence. Invalid lanes neither stall nor match. rs2 of a LOAD is not read and is not checked.
- R9: A granted lane enters the execute record on the next clock. A stalled lane sends a bubble (ex_valid 0) and keeps its decode contents.
- R10: In rigid mode (fluid_mode 0), a younger-only stall takes nothing from fetch. On the next clock the older lane is empty and the younger instruction is still held in lane 1.
- R11: In fluid mode, a younger-only stall raises steer_up and takes only presented instruction 0. On the next clock the held instruction is in lane 0 and the taken one is in lane 1.
- R12: With no stall, the whole presented group is taken (fetch_take equals in_valid) and loaded into decode on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fluid_mode | input | 1 | 1 selects fluid refill, 0 selects rigid |
| in_valid | input | 2 | Presented fetch group valid bits, bit 0 is older |
| in_cls | input | 4 | Class per lane, 2 bits each: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH |
| in_rs1 | input | 10 | First source index per lane |
| in_rs2 | input | 10 | Second source index per lane |
| in_rd | input | 10 | Destination index per lane |
| stall | output | 2 | Per-lane stall of the decode pair |
| grant | output | 2 | Per-lane issue grant of the decode pair |
| fetch_take | output | 2 | Presented instructions consumed this cycle |
| steer_up | output | 1 | Fluid move-up of the held younger instruction |
| ex_valid | output | 2 | Execute-stage lane occupied |
| ex_load | output | 2 | Execute-stage lane holds a load |
| ex_rd | output | 10 | Execute-stage destination per lane |
| dec_valid | output | 2 | Decode-stage lane occupied |
| dec_rd | output | 10 | Decode-stage destination per lane |

## Verification
Stall, grant, fetch_take and steer_up are combinational from the decode and execute registers and the presented group, so they are due in the same cycle the stimulus is applied. The ex_* and dec_* outputs reflect a decision one clock later. The driver applies a group at the falling edge and pushes one expectation built from its own model of the requirements. That expectation holds the same-cycle decision and the registered state left by the previous decision. The monitor compares it 2 ns later, so every result is sampled exactly in the cycle it is due.

// File: rtl/dls_pkg.sv
package dls_pkg;
    parameter int REG_W = 5;
    localparam int LANES = 2;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_STORE  = 2'd2,
        CLS_BRANCH = 2'd3
    } cls_e;

    typedef logic [REG_W-1:0] reg_t;

    typedef struct packed {
        logic valid;
        cls_e cls;
        reg_t rs1;
        reg_t rs2;
        reg_t rd;
    } dec_slot_t;

    typedef struct packed {
        logic valid;
        logic is_load;
        reg_t rd;
    } ex_slot_t;

    function automatic logic cls_reads_rs2(cls_e c);
        return c != CLS_LOAD;
    endfunction

    function automatic logic cls_writes_rd(cls_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction
endpackage

// File: rtl/dls_src_match.sv
module dls_src_match
    import dls_pkg::*;
#(
    parameter int NPROD = 3
) (
    input  logic [REG_W-1:0]            src,
    input  logic                        rd_en,
    input  logic [NPROD-1:0][REG_W-1:0] prod_rd,
    input  logic [NPROD-1:0]            prod_live,
    output logic                        hit
);
    logic [NPROD-1:0] match;

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        assign match[p] = prod_live[p] && (prod_rd[p] == src);
    end

    // index 0 is hardwired and never a dependence
    assign hit = rd_en && (src != '0) && (|match);
endmodule

// File: rtl/dls_slot_hazard.sv
module dls_slot_hazard
    import dls_pkg::*;
(
    input  logic                  me_valid,
    input  cls_e                  me_cls,
    input  reg_t                  me_rs1,
    input  reg_t                  me_rs2,
    input  logic                  older_valid,
    input  cls_e                  older_cls,
    input  reg_t                  older_rd,
    input  ex_slot_t [LANES-1:0]  ex,
    output logic                  dep_hit
);
    localparam int NPROD = LANES + 1;
    localparam int NSRC  = 2;

    logic [NPROD-1:0][REG_W-1:0] p_rd;
    logic [NPROD-1:0]            p_live;
    logic [NSRC-1:0]             src_hit;

    // producers: every execute lane that holds a load, then the older decode lane
    for (genvar e = 0; e < LANES; e++) begin : g_exprod
        assign p_rd[e]   = ex[e].rd;
        assign p_live[e] = ex[e].valid && ex[e].is_load;
    end
    assign p_rd[LANES]   = older_rd;
    assign p_live[LANES] = older_valid && cls_writes_rd(older_cls);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        dls_src_match #(.NPROD(NPROD)) u_match (
            .src      (s == 0 ? me_rs1 : me_rs2),
            .rd_en    (me_valid && (s == 0 ? 1'b1 : cls_reads_rs2(me_cls))),
            .prod_rd  (p_rd),
            .prod_live(p_live),
            .hit      (src_hit[s])
        );
    end

    assign dep_hit = |src_hit;
endmodule

// File: rtl/dual_ldu_stall.sv
module dual_ldu_stall
    import dls_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fluid_mode,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES*CLS_W-1:0]   in_cls,
    input  logic [LANES*REG_W-1:0]   in_rs1,
    input  logic [LANES*REG_W-1:0]   in_rs2,
    input  logic [LANES*REG_W-1:0]   in_rd,
    output logic [LANES-1:0]         stall,
    output logic [LANES-1:0]         grant,
    output logic [LANES-1:0]         fetch_take,
    output logic                     steer_up,
    output logic [LANES-1:0]         ex_valid,
    output logic [LANES-1:0]         ex_load,
    output logic [LANES*REG_W-1:0]   ex_rd,
    output logic [LANES-1:0]         dec_valid,
    output logic [LANES*REG_W-1:0]   dec_rd
);
    localparam int OLD = 0;
    localparam int YNG = 1;

    typedef struct packed {
        dec_slot_t [LANES-1:0] dec;
        ex_slot_t  [LANES-1:0] ex;
    } state_t;

    state_t                 st_q, st_d;
    dec_slot_t [LANES-1:0]  in_grp;
    logic      [LANES-1:0]  hz_hit;
    logic      [LANES-1:0]  stall_w;
    logic      [LANES-1:0]  grant_w;
    logic      [LANES-1:0]  take_d;
    logic                   steer_d;
    logic                   young_only;

    // unpack the presented fetch group
    for (genvar i = 0; i < LANES; i++) begin : g_in
        assign in_grp[i].valid = in_valid[i];
        assign in_grp[i].cls   = cls_e'(in_cls[i*CLS_W +: CLS_W]);
        assign in_grp[i].rs1   = in_rs1[i*REG_W +: REG_W];
        assign in_grp[i].rs2   = in_rs2[i*REG_W +: REG_W];
        assign in_grp[i].rd    = in_rd[i*REG_W +: REG_W];
    end

    // per-lane cross-check; the oldest lane sees an empty older neighbour
    for (genvar i = 0; i < LANES; i++) begin : g_hz
        dls_slot_hazard u_hz (
            .me_valid   (st_q.dec[i].valid),
            .me_cls     (st_q.dec[i].cls),
            .me_rs1     (st_q.dec[i].rs1),
            .me_rs2     (st_q.dec[i].rs2),
            .older_valid(i == OLD ? 1'b0 : st_q.dec[(i == OLD) ? OLD : i-1].valid),
            .older_cls  (i == OLD ? CLS_STORE : st_q.dec[(i == OLD) ? OLD : i-1].cls),
            .older_rd   (i == OLD ? '0 : st_q.dec[(i == OLD) ? OLD : i-1].rd),
            .ex         (st_q.ex),
            .dep_hit    (hz_hit[i])
        );
    end

    // age ordering: an older stall holds every younger occupied lane
    assign stall_w[OLD] = hz_hit[OLD];
    for (genvar i = 1; i < LANES; i++) begin : g_drag
        assign stall_w[i] = hz_hit[i] || (stall_w[i-1] && st_q.dec[i].valid);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_grant
        assign grant_w[i] = st_q.dec[i].valid && !stall_w[i];
    end

    assign young_only = stall_w[YNG] && !stall_w[OLD];

    always_comb begin
        st_d    = st_q;
        take_d  = '0;
        steer_d = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            st_d.ex[i].valid   = grant_w[i];
            st_d.ex[i].is_load = grant_w[i] && (st_q.dec[i].cls == CLS_LOAD);
            st_d.ex[i].rd      = grant_w[i] ? st_q.dec[i].rd : '0;
        end
        if (stall_w[OLD]) begin
            st_d.dec = st_q.dec;
        end else if (young_only) begin
            if (fluid_mode) begin
                st_d.dec[OLD] = st_q.dec[YNG];
                st_d.dec[YNG] = in_grp[OLD];
                take_d[OLD]   = in_valid[OLD];
                steer_d       = 1'b1;
            end else begin
                st_d.dec[OLD] = '0;
                st_d.dec[YNG] = st_q.dec[YNG];
            end
        end else begin
            st_d.dec = in_grp;
            take_d   = in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall      = stall_w;
    assign grant      = grant_w;
    assign fetch_take = take_d;
    assign steer_up   = steer_d;

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign ex_valid[i]               = st_q.ex[i].valid;
        assign ex_load[i]                = st_q.ex[i].is_load;
        assign ex_rd[i*REG_W +: REG_W]   = st_q.ex[i].rd;
        assign dec_valid[i]              = st_q.dec[i].valid;
        assign dec_rd[i*REG_W +: REG_W]  = st_q.dec[i].rd;
    end

    // R9
    older_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_w[OLD] |=> (!st_q.ex[OLD].valid && st_q.dec[OLD] == $past(st_q.dec[OLD])));

    // R5
    drag_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_w[OLD] |=> !st_q.ex[YNG].valid);

    // R6
    older_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dec[OLD].valid && !stall_w[OLD]) |=> st_q.ex[OLD].valid);

    // R10
    rigid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fluid_mode && young_only) |=>
            (!st_q.dec[OLD].valid && st_q.dec[YNG] == $past(st_q.dec[YNG])));

    // R11
    fluid_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fluid_mode && young_only) |=> st_q.dec[OLD] == $past(st_q.dec[YNG]));
endmodule

// File: tb/dual_ldu_stall_tb.sv
module dual_ldu_stall_tb;
    import dls_pkg::*;

    typedef struct {
        logic [1:0]         st, gr, tk;
        logic               sp;
        logic [1:0]         exv, exl, dv;
        logic [2*REG_W-1:0] exrd, drd;
        string              tag_s, tag_t;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, fluid_mode = 1'b0;
    logic [1:0] in_valid = '0;
    logic [3:0] in_cls = '0;
    logic [2*REG_W-1:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic [1:0] stall, grant, fetch_take, ex_valid, ex_load, dec_valid;
    logic steer_up;
    logic [2*REG_W-1:0] ex_rd, dec_rd;

    int checks = 0, fails = 0, pc = 0;
    dec_slot_t prog[$];
    dec_slot_t mdec[2];
    ex_slot_t  mex[2];
    exp_t      q[$];

    always #5 clk = ~clk;

    dual_ldu_stall u_dut (
        .clk(clk), .rst_n(rst_n), .fluid_mode(fluid_mode),
        .in_valid(in_valid), .in_cls(in_cls), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
        .stall(stall), .grant(grant), .fetch_take(fetch_take), .steer_up(steer_up),
        .ex_valid(ex_valid), .ex_load(ex_load), .ex_rd(ex_rd),
        .dec_valid(dec_valid), .dec_rd(dec_rd)
    );

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic dec_slot_t mk(cls_e c, int s1, int s2, int d);
        dec_slot_t x;
        x.valid = 1'b1; x.cls = c;
        x.rs1 = REG_W'(s1); x.rs2 = REG_W'(s2); x.rd = REG_W'(d);
        return x;
    endfunction

    function automatic bit src_dep(reg_t s, dec_slot_t older, bit use_older);
        if (s == '0) return 1'b0;
        for (int j = 0; j < 2; j++)
            if (mex[j].valid && mex[j].is_load && mex[j].rd == s) return 1'b1;
        if (use_older && older.valid && (older.cls == CLS_ALU || older.cls == CLS_LOAD)
            && older.rd == s) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit dep(dec_slot_t me, dec_slot_t older, bit use_older);
        if (!me.valid) return 1'b0;
        return src_dep(me.rs1, older, use_older) ||
               (me.cls != CLS_LOAD && src_dep(me.rs2, older, use_older));
    endfunction

    // driver: presents the next two program instructions and predicts the outcome
    task automatic step();
        dec_slot_t i0, i1, empty;
        dec_slot_t nd[2];
        exp_t e;
        bit s0, s1, lu1;
        logic [1:0] g, tk;
        bit sp;
        empty = '0;
        @(negedge clk);
        i0 = (pc < prog.size()) ? prog[pc] : empty;
        i1 = (pc + 1 < prog.size()) ? prog[pc+1] : empty;
        in_valid = {i1.valid, i0.valid};
        in_cls   = {i1.cls, i0.cls};
        in_rs1   = {i1.rs1, i0.rs1};
        in_rs2   = {i1.rs2, i0.rs2};
        in_rd    = {i1.rd, i0.rd};
        s0  = dep(mdec[0], empty, 1'b0);
        lu1 = dep(mdec[1], empty, 1'b0);
        s1  = dep(mdec[1], mdec[0], 1'b1) || (s0 && mdec[1].valid);
        g   = {mdec[1].valid && !s1, mdec[0].valid && !s0};
        e.st = {s1, s0}; e.gr = g;
        e.exv  = {mex[1].valid, mex[0].valid};
        e.exl  = {mex[1].is_load, mex[0].is_load};
        e.exrd = {mex[1].rd, mex[0].rd};
        e.dv   = {mdec[1].valid, mdec[0].valid};
        e.drd  = {mdec[1].rd, mdec[0].rd};
        nd = mdec; tk = '0; sp = 1'b0;
        if (s0) begin
        end else if (s1) begin
            if (fluid_mode) begin
                nd[0] = mdec[1]; nd[1] = i0; tk = {1'b0, i0.valid}; sp = 1'b1;
            end else begin
                nd[0] = empty;
            end
        end else begin
            nd[0] = i0; nd[1] = i1; tk = {i1.valid, i0.valid};
        end
        e.tk = tk; e.sp = sp;
        e.tag_s = s0 ? "R2 R5" : (s1 ? (lu1 ? "R3 R6" : "R4 R6") : "R7 R8 R12");
        e.tag_t = (!s0 && s1) ? (fluid_mode ? "R11" : "R10") : "R12";
        q.push_back(e);
        for (int j = 0; j < 2; j++) begin
            mex[j].valid   = g[j];
            mex[j].is_load = g[j] && mdec[j].cls == CLS_LOAD;
            mex[j].rd      = g[j] ? mdec[j].rd : '0;
        end
        mdec = nd;
        pc += int'(tk[0]) + int'(tk[1]);
    endtask

    // monitor: pops each expectation in the cycle it is due
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk({stall, grant} == {e.st, e.gr}, e.tag_s, "stall/grant",
                    32'({stall, grant}), 32'({e.st, e.gr}));
                chk({fetch_take, steer_up} == {e.tk, e.sp}, e.tag_t, "take/steer",
                    32'({fetch_take, steer_up}), 32'({e.tk, e.sp}));
                chk({ex_valid, ex_load, ex_rd} == {e.exv, e.exl, e.exrd}, "R9", "execute record",
                    32'({ex_valid, ex_load, ex_rd}), 32'({e.exv, e.exl, e.exrd}));
                chk({dec_valid, dec_rd} == {e.dv, e.drd}, "R9 R10 R11", "decode pair",
                    32'({dec_valid, dec_rd}), 32'({e.dv, e.drd}));
            end
        end
    end

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = '0; in_cls = '0; in_rs1 = '0; in_rs2 = '0; in_rd = '0;
        for (int j = 0; j < 2; j++) begin mdec[j] = '0; mex[j] = '0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: empty pipeline and quiet controls after reset
        chk({dec_valid, ex_valid} == 4'b0, "R1", "lanes empty", 32'({dec_valid, ex_valid}), 0);
        chk({stall, grant, fetch_take, steer_up} == 7'b0, "R1", "controls idle",
            32'({stall, grant, fetch_take, steer_up}), 0);
    endtask

    task automatic run_prog(bit fl);
        fluid_mode = fl;
        reset_dut();
        pc = 0;
        while (pc < prog.size() || mdec[0].valid || mdec[1].valid) step();
        step();
        step();
    endtask

    initial begin
        prog.push_back(mk(CLS_LOAD, 1, 0, 5));    prog.push_back(mk(CLS_ALU, 2, 3, 6));
        prog.push_back(mk(CLS_ALU, 5, 4, 7));     prog.push_back(mk(CLS_ALU, 9, 10, 8));   // R2 older load-use
        prog.push_back(mk(CLS_ALU, 8, 1, 11));    prog.push_back(mk(CLS_LOAD, 7, 0, 12));  // R7 ALU producers
        prog.push_back(mk(CLS_ALU, 1, 2, 14));    prog.push_back(mk(CLS_ALU, 12, 3, 15));  // R3 younger vs lane 1
        prog.push_back(mk(CLS_LOAD, 20, 14, 16)); prog.push_back(mk(CLS_ALU, 16, 1, 17));  // R4 intra-pair
        prog.push_back(mk(CLS_LOAD, 1, 0, 0));    prog.push_back(mk(CLS_ALU, 0, 0, 18));   // R8 register 0
        prog.push_back(mk(CLS_LOAD, 1, 0, 20));   prog.push_back(mk(CLS_ALU, 2, 3, 21));
        prog.push_back(mk(CLS_LOAD, 4, 20, 22));  prog.push_back(mk(CLS_ALU, 5, 6, 23));   // R8 load rs2 unread
        prog.push_back(mk(CLS_STORE, 1, 2, 23));  prog.push_back(mk(CLS_ALU, 23, 1, 24));  // R8 store writes nothing
        prog.push_back(mk(CLS_LOAD, 1, 0, 25));   prog.push_back(mk(CLS_BRANCH, 3, 4, 0));
        prog.push_back(mk(CLS_BRANCH, 5, 25, 0)); prog.push_back(mk(CLS_ALU, 25, 2, 26));  // R2 via rs2
        run_prog(1'b0);
        run_prog(1'b1);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R12: actual timeout expected program drained");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule